// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the oversampling strobe for an asynchronous serial port from a fixed 48 MHz reference. The strobe rate is 48 MHz divided by (n + x), so that a UART sampling sixteen times per bit runs at 3,000,000 / (n + x) baud. Here n is a 14-bit integer divisor and x is a fraction in eighths (0 to 0.875) given by a 3-bit code. Every strobe period lasts either n or n + 1 reference cycles. An eighths accumulator decides which periods get the extra cycle, so that over any eight periods the average length is exactly n + x. This covers rates from roughly 183 baud up to 3 Mbaud.

A new setting is presented on the configuration inputs together with a one-cycle load strobe. It is held as pending and is applied only at the next strobe boundary, so the period already in progress is never cut short or stretched. Two settings are illegal and are remapped rather than used directly:
- An integer of 0 stands for 16384.
- An integer of 1 is legal only with a zero fraction, which selects the fastest rate of one strobe per cycle. An integer of 1 with a non-zero fraction is treated as a divisor of exactly 2.

A second output marks every sixteenth strobe, which is one pulse per bit time.

The sequencer has three named states:
- COUNT: counts the integer part of the period down to zero.
- STRETCH: the single extra cycle inserted when the accumulator overflows.
- FAST: the divisor is 1 and a strobe is issued every cycle.

The state transitions are:
- COUNT→COUNT: the count has not yet reached zero, or it reached zero with no overflow, the strobe was issued and the next setting is a normal divisor.
- COUNT→STRETCH: the count reached zero and the accumulator overflowed.
- COUNT→FAST, STRETCH→FAST, FAST→FAST: a strobe is issued and the setting now in force has divisor 1.
- STRETCH→COUNT, FAST→COUNT: a strobe is issued and the setting now in force is a normal divisor.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is high, both strobes are low. After reset the default divisor (26, fraction 0) is in force, and the first strobe falls on the 26th cycle after the last reset edge.
- R2: With an integer n from 2 to 16383 and fraction code 0, `os_tick` is high for exactly one cycle in every n cycles.
- R3: With fraction code f (value f/8), the k-th period after a setting takes effect lasts n + 1 cycles when floor(k·f/8) > floor((k−1)·f/8), and n cycles otherwise. The accumulator starts from zero whenever a setting takes effect.
- R4: An integer code of 0 gives periods of 16384 cycles plus the fractional stretch.
- R5: An integer code of 1 with fraction code 0 gives a strobe on every cycle.
- R6: An integer code of 1 with a non-zero fraction code gives a fixed period of 2 cycles, and the fraction has no effect.
- R7: A setting loaded with `cfg_load` takes effect from the period that starts after the next strobe. The period in flight keeps its old length, whatever cycle the load arrives in.
- R8: If several loads arrive before a strobe boundary, only the last one is applied.
- R9: `baud_tick` is high together with every sixteenth `os_tick` counted since reset, including across reloads, and is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | One-cycle strobe that captures a new setting |
| cfg_int | input | 14 | Integer divisor code (0 means 16384) |
| cfg_frac | input | 3 | Fraction in eighths |
| os_tick | output | 1 | One-cycle oversampling strobe |
| baud_tick | output | 1 | One-cycle strobe on every sixteenth `os_tick` |

## Verification
Each strobe is due a whole number of cycles after the previous one, with no fixed latency after a stimulus. The bench therefore measures the interval from one strobe to the next and compares it with the length its model predicts for that period. A load is registered one cycle after it is driven and has no effect on the period already running. For that reason the driver queues the expected lengths of the new setting behind the one in-flight period of the old setting, and it loads only once the queue has drained to that single period, sometimes after an extra delay inside the period. The per-bit strobe is checked in the very cycle of each oversampling strobe, against a running count of strobes since reset.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

    localparam int BG_INT_W  = 14;
    localparam int BG_FRAC_W = 3;
    localparam int BG_N_W    = BG_INT_W + 1;
    localparam int BG_MAX_N  = 1 << BG_INT_W;

    typedef enum logic [1:0] {
        ST_COUNT   = 2'd0,
        ST_STRETCH = 2'd1,
        ST_FAST    = 2'd2
    } bg_state_e;

    typedef struct packed {
        logic [BG_N_W-1:0]    n;
        logic [BG_FRAC_W-1:0] frac;
        logic                 fast;
    } bg_div_t;

    // Turn a raw setting into the divisor actually used.
    function automatic bg_div_t bg_map(input logic [BG_INT_W-1:0]  i_code,
                                       input logic [BG_FRAC_W-1:0] f_code);
        bg_div_t d;
        d.n    = {1'b0, i_code};
        d.frac = f_code;
        d.fast = 1'b0;
        if (i_code == '0) begin
            d.n = BG_N_W'(BG_MAX_N);
        end else if (i_code == BG_INT_W'(1)) begin
            if (f_code == '0) begin
                d.fast = 1'b1;
            end else begin
                d.n    = BG_N_W'(2);
                d.frac = '0;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/bgen_cfg_hold.sv
module bgen_cfg_hold
    import bgen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_load,
    input  logic [BG_INT_W-1:0]  cfg_int,
    input  logic [BG_FRAC_W-1:0] cfg_frac,
    input  logic                 os_tick,
    output bg_div_t              pend,
    output logic                 pend_valid
);

    bg_div_t mapped;

    assign mapped = bg_map(cfg_int, cfg_frac);

    // Last load wins; the pending entry is consumed at a strobe boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= '0;
            pend_valid <= 1'b0;
        end else if (cfg_load) begin
            pend       <= mapped;
            pend_valid <= 1'b1;
        end else if (os_tick && pend_valid) begin
            pend_valid <= 1'b0;
        end
    end

    // R6 / R4: remapped divisors stay within the legal span
    always_comb begin
        if (!rst) begin
            p_map_legal_r6: assert (mapped.n >= BG_N_W'(1) && mapped.n <= BG_N_W'(BG_MAX_N)
                                    && (mapped.fast == (mapped.n == BG_N_W'(1))));
        end
    end

    // R7: a pending setting is consumed by the strobe that ends the period
    p_pend_consumed_r7: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && os_tick && !cfg_load) |=> !pend_valid);

endmodule

// File: rtl/bgen_core.sv
module bgen_core
    import bgen_pkg::*;
#(
    parameter logic [BG_INT_W-1:0]  RST_INT  = 14'd26,
    parameter logic [BG_FRAC_W-1:0] RST_FRAC = 3'd0
) (
    input  logic    clk,
    input  logic    rst,
    input  bg_div_t pend,
    input  logic    pend_valid,
    output logic    os_tick
);

    localparam int      CNT_W   = BG_INT_W;
    localparam bg_div_t RST_DIV = bg_map(RST_INT, RST_FRAC);

    bg_state_e             state_q, state_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic [BG_FRAC_W-1:0]  acc_q, acc_d;
    bg_div_t               act_q, act_d;
    logic [BG_FRAC_W:0]    sum;
    logic                  take;
    bg_div_t               nxt_div;

    assign sum     = {1'b0, acc_q} + {1'b0, act_q.frac};
    assign take    = os_tick && pend_valid;
    assign nxt_div = take ? pend : act_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RST_DIV.fast ? ST_FAST : ST_COUNT;
            cnt_q   <= CNT_W'(RST_DIV.n - BG_N_W'(1));
            acc_q   <= '0;
            act_q   <= RST_DIV;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            acc_q   <= acc_d;
            act_q   <= act_d;
        end
    end

    // Output decode
    always_comb begin
        os_tick = 1'b0;
        unique case (state_q)
            ST_COUNT:   os_tick = (cnt_q == '0) && !sum[BG_FRAC_W];
            ST_STRETCH: os_tick = 1'b1;
            ST_FAST:    os_tick = 1'b1;
            default:    os_tick = 1'b0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        acc_d   = acc_q;
        act_d   = act_q;
        unique case (state_q)
            ST_COUNT: begin
                if (cnt_q == '0) begin
                    acc_d = sum[BG_FRAC_W-1:0];
                    if (sum[BG_FRAC_W]) begin
                        state_d = ST_STRETCH;
                    end
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_STRETCH: begin
                state_d = ST_COUNT;
            end
            ST_FAST: begin
                state_d = ST_FAST;
            end
            default: begin
                state_d = ST_COUNT;
            end
        endcase
        if (os_tick) begin
            act_d   = nxt_div;
            state_d = nxt_div.fast ? ST_FAST : ST_COUNT;
            cnt_d   = CNT_W'(nxt_div.n - BG_N_W'(1));
            if (take) begin
                acc_d = '0;
            end
        end
    end

    // Cycles elapsed in the current period, kept for checking only
    logic [BG_N_W-1:0] since_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
        end else if (os_tick) begin
            since_q <= '0;
        end else begin
            since_q <= since_q + BG_N_W'(1);
        end
    end

    // R3: each period lasts n cycles, or n+1 only when a fraction is set
    p_period_len_r3: assert property (@(posedge clk) disable iff (rst)
        os_tick |-> ((since_q + BG_N_W'(1)) == act_q.n)
                    || ((since_q == act_q.n) && (act_q.frac != '0)));

    // R3: a stretch never lasts more than one cycle
    p_stretch_single_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STRETCH) |=> (state_q != ST_STRETCH));

    // R7: the setting in force changes only right after a strobe
    p_cfg_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !os_tick |=> ($stable(act_q.n) && $stable(act_q.frac)));

endmodule

// File: rtl/bgen_os_div.sv
module bgen_os_div #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic os_tick,
    output logic baud_tick
);

    localparam int W = $clog2(RATIO);

    logic [W-1:0] cnt_q;

    assign baud_tick = os_tick && (cnt_q == W'(RATIO - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (os_tick) begin
            cnt_q <= (cnt_q == W'(RATIO - 1)) ? '0 : cnt_q + W'(1);
        end
    end

    // R9: per-bit strobes are never back to back
    p_baud_gap_r9: assert property (@(posedge clk) disable iff (rst)
        baud_tick |=> !baud_tick);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import bgen_pkg::*;
#(
    parameter logic [BG_INT_W-1:0]  RST_INT  = 14'd26,
    parameter logic [BG_FRAC_W-1:0] RST_FRAC = 3'd0,
    parameter int                   OS_RATIO = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_load,
    input  logic [BG_INT_W-1:0]  cfg_int,
    input  logic [BG_FRAC_W-1:0] cfg_frac,
    output logic                 os_tick,
    output logic                 baud_tick
);

    bg_div_t pend;
    logic    pend_valid;

    bgen_cfg_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .cfg_load   (cfg_load),
        .cfg_int    (cfg_int),
        .cfg_frac   (cfg_frac),
        .os_tick    (os_tick),
        .pend       (pend),
        .pend_valid (pend_valid)
    );

    bgen_core #(
        .RST_INT  (RST_INT),
        .RST_FRAC (RST_FRAC)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .pend       (pend),
        .pend_valid (pend_valid),
        .os_tick    (os_tick)
    );

    bgen_os_div #(
        .RATIO (OS_RATIO)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .os_tick   (os_tick),
        .baud_tick (baud_tick)
    );

endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [13:0] cfg_int = '0;
    logic [2:0]  cfg_frac = '0;
    logic        os_tick;
    logic        baud_tick;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    int    lq[$];
    string rq[$];

    always #10 clk = ~clk;

    frac_baud_gen u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .cfg_int   (cfg_int),
        .cfg_frac  (cfg_frac),
        .os_tick   (os_tick),
        .baud_tick (baud_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected length of the k-th period after a setting takes effect.
    function automatic int exp_len(input int n, input int f, input int k);
        int ne;
        int fe;
        ne = (n == 0) ? 16384 : ((n == 1 && f != 0) ? 2 : n);
        fe = (n == 1) ? 0 : f;
        return ne + ((k * fe) / 8 - ((k - 1) * fe) / 8);
    endfunction

    task automatic push_cfg(input int n, input int f, input int k, input string req);
        for (int j = 1; j <= k; j++) begin
            lq.push_back(exp_len(n, f, j));
            rq.push_back(req);
        end
    endtask

    task automatic do_cfg(input int n, input int f, input int k, input int dly,
                          input bit decoy, input string req);
        while (lq.size() > 1) begin
            @(posedge clk);
            #1;
        end
        repeat (dly) begin
            @(posedge clk);
            #1;
        end
        if (decoy) begin
            cfg_int  = 14'd7;
            cfg_frac = 3'd2;
            cfg_load = 1'b1;
            @(posedge clk);
            #1;
        end
        push_cfg(n, f, k, req);
        cfg_int  = 14'(n);
        cfg_frac = 3'(f);
        cfg_load = 1'b1;
        @(posedge clk);
        #1;
        cfg_load = 1'b0;
    endtask

    // Monitor: measures strobe intervals and the per-bit strobe.
    initial begin
        int cyc;
        int ntk;
        int e;
        string r;
        cyc = 0;
        ntk = 0;
        forever begin
            @(negedge clk);
            if (!rst && !done) begin
                cyc++;
                if (os_tick) begin
                    if (lq.size() > 0) begin
                        e = lq.pop_front();
                        r = rq.pop_front();
                        chk(cyc == e, r, cyc, e);
                    end
                    chk(baud_tick == ((ntk % 16) == 15), "R9", int'(baud_tick),
                        int'((ntk % 16) == 15));
                    ntk++;
                    cyc = 0;
                end else if (baud_tick) begin
                    chk(1'b0, "R9", 1, 0);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "watchdog", lq.size(), 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state and default divisor of 26
        push_cfg(26, 0, 3, "R1");
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(os_tick == 1'b0, "R1", int'(os_tick), 0);
        chk(baud_tick == 1'b0, "R1", int'(baud_tick), 0);
        @(posedge clk);
        #1;
        rst = 1'b0;

        do_cfg(2,     0, 8,  0,    1'b0, "R2");
        do_cfg(40,    0, 4,  0,    1'b0, "R2");
        do_cfg(5,     5, 16, 10,   1'b0, "R7");
        do_cfg(100,   7, 16, 0,    1'b0, "R3");
        do_cfg(3,     3, 16, 50,   1'b1, "R8");
        do_cfg(1,     4, 8,  0,    1'b0, "R6");
        do_cfg(16383, 0, 1,  0,    1'b0, "R2");
        do_cfg(0,     0, 2,  1000, 1'b0, "R4");
        do_cfg(9,     1, 16, 0,    1'b0, "R3");
        do_cfg(1,     0, 20, 0,    1'b0, "R5");

        while (lq.size() > 0) begin
            @(posedge clk);
            #1;
        end
        repeat (40) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule